// File: doc/BRIEF.md
# Bank Chip-Select and Bus Timing Sequencer

This block turns bus cycles from a processor into chip-select, read-strobe and byte-write-strobe activity for eight ROM and I/O banks. Each bank holds a configuration word with an enable bit, a size code, a base address and two timing sets, one for reads and one for writes. The timing sets give the setup, access, hold and recovery lengths in clocks. The block ends each access with its own one-clock transfer acknowledge, so slow memories need no external acknowledge logic. An external wait input can lengthen the access phase for devices that need more time than their bank's setting.

A cycle request (`cyc_valid` with address, direction and byte enables) is accepted only while the sequencer is idle. The decoder picks the lowest-numbered enabled bank whose window contains the address. The sequencer latches that bank and its timing set, then walks through its states. `ST_IDLE` moves to `ST_SETUP` when the setup count is non-zero, and straight to `ST_ACCESS` otherwise. `ST_SETUP` moves to `ST_ACCESS` when its count runs out. `ST_ACCESS` moves to `ST_HOLD`, `ST_RECOVER` or `ST_IDLE`, taking the first of these whose count is non-zero, once its count is exhausted and `ext_wait` is low. `ST_HOLD` moves to `ST_RECOVER` or `ST_IDLE`. `ST_RECOVER` moves to `ST_IDLE`.

Configuration words are written through a write-only port that selects a bank by number. Bank 0 is usable straight out of reset as a boot bank.

Top module: `csel_timing_unit`

## Requirements
- R1: At most one bit of `cs` is high in any cycle. It is the bit of the latched bank, and it is high during setup, access and hold only. A strobe is never high without a chip select.
- R2: A write on the configuration port with `cfg_we` high stores `cfg_wdata` into bank `cfg_bank`. The fields are: enable at bit 31, size code at bits 30:27, base at bits 26:17 (address bits 27:18), write timing at bits 15:8 and read timing at bits 7:0. Bit 16 is unused. Within each timing byte, setup is at bits 1:0, access at 3:2, hold at 5:4 and recovery at 7:6.
- R3: Size code k selects a window of 256 KB shifted left by k. Codes 0 to 8 cover 256 KB to 64 MB, and codes above 8 act as 64 MB. Base bits below the window size are ignored, so each window is aligned to its own size.
- R4: After reset, bank 0 is enabled with base 0, an 8 MB window and every timing field set to 3. Banks 1 to 7 are disabled, and all outputs are low.
- R5: A request whose address matches no enabled bank produces no chip select, no strobe and no acknowledge. A disabled bank never matches.
- R6: When several enabled banks match an address, the lowest-numbered one is selected.
- R7: An accepted cycle uses the read timing set for reads and the write timing set for writes. It gives S setup clocks, A+1+W strobe clocks (W being the extra wait clocks), H hold clocks and then R recovery clocks with all chip selects low. One idle clock follows before the next request is accepted.
- R8: `ack` is high for exactly one clock, the last clock of the strobe phase.
- R9: While `ext_wait` is high in a strobe clock whose access count is exhausted, the strobe phase continues and `ack` stays low.
- R10: A read raises `rd_stb` only. A write raises `wr_hi_stb` when `cyc_be_hi` is set (data bits 15:8) and `wr_lo_stb` when `cyc_be_lo` is set (data bits 7:0).
- R11: A request presented while a cycle or its recovery is in progress is dropped and starts nothing.
- R12: Bank and timing are latched when a cycle starts. Rewriting the configuration during the cycle changes only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_bank | input | 3 | Bank number to write |
| cfg_wdata | input | 32 | Configuration word |
| cyc_valid | input | 1 | Bus cycle request |
| cyc_addr | input | 28 | Byte address of the request |
| cyc_rd | input | 1 | 1 = read, 0 = write |
| cyc_be_hi | input | 1 | Upper byte enable (bits 15:8) |
| cyc_be_lo | input | 1 | Lower byte enable (bits 7:0) |
| ext_wait | input | 1 | Stretches the strobe phase while high |
| cs | output | 8 | Active-high chip selects, one per bank |
| rd_stb | output | 1 | Read strobe |
| wr_hi_stb | output | 1 | Upper byte write strobe |
| wr_lo_stb | output | 1 | Lower byte write strobe |
| ack | output | 1 | Internally generated transfer acknowledge |

## Verification
The bench places overlapping windows so that a priority encoder which favoured the higher bank would assert the wrong chip select. It programs a misaligned base and an oversized size code, which would move or shrink a window if the decoder failed to mask base bits or clamp the code. It holds `ext_wait` past the programmed access count and rewrites a bank's timing in the middle of its own cycle. A sequencer that ignored the wait would acknowledge early, and one that did not latch its timing would cut the cycle short. It also holds a request high across consecutive cycles to measure the recovery gap, and it pulses a request during a busy cycle, which a design that did not gate new requests would start as an extra cycle.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int CS_BANKS       = 8;
    localparam int CS_ADDR_W      = 28;
    localparam int CS_GRAN_LOG2   = 18;
    localparam int CS_BASE_W      = CS_ADDR_W - CS_GRAN_LOG2;
    localparam int CS_SIZE_W      = 4;
    localparam int CS_MAX_CODE    = 8;
    localparam int CS_TIME_W      = 2;
    localparam int CS_CFG_W       = 32;
    localparam int CS_BOOT_CODE   = 5;

    typedef struct packed {
        logic [CS_TIME_W-1:0] rec;
        logic [CS_TIME_W-1:0] hold;
        logic [CS_TIME_W-1:0] acc;
        logic [CS_TIME_W-1:0] setup;
    } phase_t;

    typedef struct packed {
        logic                 en;
        logic [CS_SIZE_W-1:0] size;
        logic [CS_BASE_W-1:0] base;
        phase_t               wr;
        phase_t               rd;
    } bank_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_RECOVER
    } seq_state_t;
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
    import csel_pkg::*;
#(
    parameter int NB    = CS_BANKS,
    parameter int IDX_W = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_bank,
    input  logic [CS_CFG_W-1:0]  cfg_wdata,
    output bank_cfg_t [NB-1:0]   cfg
);
    localparam bank_cfg_t BOOT_CFG = '{
        en:   1'b1,
        size: CS_SIZE_W'(CS_BOOT_CODE),
        base: '0,
        wr:   8'hFF,
        rd:   8'hFF
    };

    logic unused_gap;
    assign unused_gap = cfg_wdata[16];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                cfg[i] <= '0;
            end
            cfg[0] <= BOOT_CFG;
        end else if (cfg_we) begin
            cfg[cfg_bank] <= bank_cfg_t'({cfg_wdata[31:17], cfg_wdata[15:0]});
        end
    end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
    import csel_pkg::*;
#(
    parameter int NB    = CS_BANKS,
    parameter int IDX_W = $clog2(NB)
) (
    input  bank_cfg_t [NB-1:0]    cfg,
    input  logic [CS_BASE_W-1:0]  addr_hi,
    output logic                  hit,
    output logic [IDX_W-1:0]      hit_idx
);
    logic [NB-1:0] match;

    for (genvar gi = 0; gi < NB; gi++) begin : g_bank
        logic [CS_SIZE_W-1:0] code_c;
        logic [CS_BASE_W-1:0] mask;
        logic                 unused_tim;
        assign unused_tim = ^{cfg[gi].wr, cfg[gi].rd};
        always_comb begin
            code_c = (cfg[gi].size > CS_SIZE_W'(CS_MAX_CODE))
                   ? CS_SIZE_W'(CS_MAX_CODE) : cfg[gi].size;
            mask   = ~((CS_BASE_W'(1) << code_c) - CS_BASE_W'(1));
            match[gi] = cfg[gi].en && (((addr_hi ^ cfg[gi].base) & mask) == '0);
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/csel_seq.sv
module csel_seq
    import csel_pkg::*;
#(
    parameter int NB    = CS_BANKS,
    parameter int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_bank,
    input  logic             start_rd,
    input  logic             start_hi,
    input  logic             start_lo,
    input  phase_t           start_ph,
    input  logic             ext_wait,
    output logic [NB-1:0]    cs,
    output logic             rd_stb,
    output logic             wr_hi_stb,
    output logic             wr_lo_stb,
    output logic             ack
);
    localparam logic [CS_TIME_W-1:0] T_ONE = CS_TIME_W'(1);

    seq_state_t           state, state_d;
    logic [CS_TIME_W-1:0] cnt, cnt_d;
    logic                 load;
    logic [IDX_W-1:0]     bank_q;
    logic                 rd_q, hi_q, lo_q;
    phase_t               ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bank_q <= '0;
            rd_q   <= 1'b0;
            hi_q   <= 1'b0;
            lo_q   <= 1'b0;
            ph_q   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            if (load) begin
                bank_q <= start_bank;
                rd_q   <= start_rd;
                hi_q   <= start_hi;
                lo_q   <= start_lo;
                ph_q   <= start_ph;
            end
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (start_ph.setup != '0) begin
                        state_d = ST_SETUP;
                        cnt_d   = start_ph.setup - T_ONE;
                    end else begin
                        state_d = ST_ACCESS;
                        cnt_d   = start_ph.acc;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    state_d = ST_ACCESS;
                    cnt_d   = ph_q.acc;
                end else begin
                    cnt_d = cnt - T_ONE;
                end
            end
            ST_ACCESS: begin
                if (cnt != '0) begin
                    cnt_d = cnt - T_ONE;
                end else if (!ext_wait) begin
                    if (ph_q.hold != '0) begin
                        state_d = ST_HOLD;
                        cnt_d   = ph_q.hold - T_ONE;
                    end else if (ph_q.rec != '0) begin
                        state_d = ST_RECOVER;
                        cnt_d   = ph_q.rec - T_ONE;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt != '0) begin
                    cnt_d = cnt - T_ONE;
                end else if (ph_q.rec != '0) begin
                    state_d = ST_RECOVER;
                    cnt_d   = ph_q.rec - T_ONE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RECOVER: begin
                if (cnt != '0) begin
                    cnt_d = cnt - T_ONE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cs        = '0;
        rd_stb    = 1'b0;
        wr_hi_stb = 1'b0;
        wr_lo_stb = 1'b0;
        ack       = 1'b0;
        if (state == ST_SETUP || state == ST_ACCESS || state == ST_HOLD) begin
            cs[bank_q] = 1'b1;
        end
        if (state == ST_ACCESS) begin
            rd_stb    = rd_q;
            wr_hi_stb = !rd_q && hi_q;
            wr_lo_stb = !rd_q && lo_q;
            ack       = (cnt == '0) && !ext_wait;
        end
    end
endmodule

// File: rtl/csel_timing_unit.sv
module csel_timing_unit
    import csel_pkg::*;
#(
    parameter int NB     = CS_BANKS,
    parameter int ADDR_W = CS_ADDR_W,
    parameter int GRAN   = CS_GRAN_LOG2,
    parameter int IDX_W  = $clog2(NB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_bank,
    input  logic [CS_CFG_W-1:0] cfg_wdata,
    input  logic                cyc_valid,
    input  logic [ADDR_W-1:0]   cyc_addr,
    input  logic                cyc_rd,
    input  logic                cyc_be_hi,
    input  logic                cyc_be_lo,
    input  logic                ext_wait,
    output logic [NB-1:0]       cs,
    output logic                rd_stb,
    output logic                wr_hi_stb,
    output logic                wr_lo_stb,
    output logic                ack
);
    bank_cfg_t [NB-1:0] cfg;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    phase_t             sel_ph;
    logic               unused_low;

    assign unused_low = ^cyc_addr[GRAN-1:0];

    csel_regfile #(.NB(NB), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_bank  (cfg_bank),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    csel_decoder #(.NB(NB), .IDX_W(IDX_W)) u_dec (
        .cfg     (cfg),
        .addr_hi (cyc_addr[ADDR_W-1:GRAN]),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    assign sel_ph = cyc_rd ? cfg[hit_idx].rd : cfg[hit_idx].wr;

    csel_seq #(.NB(NB), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cyc_valid && hit),
        .start_bank (hit_idx),
        .start_rd   (cyc_rd),
        .start_hi   (cyc_be_hi),
        .start_lo   (cyc_be_lo),
        .start_ph   (sel_ph),
        .ext_wait   (ext_wait),
        .cs         (cs),
        .rd_stb     (rd_stb),
        .wr_hi_stb  (wr_hi_stb),
        .wr_lo_stb  (wr_lo_stb),
        .ack        (ack)
    );
endmodule

// File: rtl/csel_checker.sv
module csel_checker #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_wait,
    input logic [NB-1:0] cs,
    input logic          rd_stb,
    input logic          wr_hi_stb,
    input logic          wr_lo_stb,
    input logic          ack
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs)); // R1
    AST_STB_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_hi_stb || wr_lo_stb) |-> (cs != '0)); // R1
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && (wr_hi_stb || wr_lo_stb))); // R10
    AST_ACK_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8
    AST_ACK_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs != '0)); // R8
    AST_WAIT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wait |-> !ack); // R9
    AST_WAIT_KEEPS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ext_wait) |=> rd_stb); // R9
    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs != '0) && ($past(cs) != '0)) |-> (cs == $past(cs))); // R12
endmodule

bind csel_timing_unit csel_checker #(.NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_wait  (ext_wait),
    .cs        (cs),
    .rd_stb    (rd_stb),
    .wr_hi_stb (wr_hi_stb),
    .wr_lo_stb (wr_lo_stb),
    .ack       (ack)
);

// File: tb/tb_csel_timing_unit.sv
`timescale 1ns/1ps
module tb_csel_timing_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cyc_valid = 1'b0;
    logic [27:0] cyc_addr = '0;
    logic        cyc_rd = 1'b0;
    logic        cyc_be_hi = 1'b0;
    logic        cyc_be_lo = 1'b0;
    logic        ext_wait = 1'b0;
    logic [7:0]  cs;
    logic        rd_stb, wr_hi_stb, wr_lo_stb, ack;

    int total = 0;
    int bad = 0;
    logic [7:0] mr [8];
    logic [7:0] mw [8];

    always #2.5 clk = ~clk;

    csel_timing_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wdata(cfg_wdata), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_rd(cyc_rd), .cyc_be_hi(cyc_be_hi), .cyc_be_lo(cyc_be_lo),
        .ext_wait(ext_wait), .cs(cs), .rd_stb(rd_stb), .wr_hi_stb(wr_hi_stb),
        .wr_lo_stb(wr_lo_stb), .ack(ack)
    );

    // row: {addr[27:0], rd, be_hi, be_lo, waits[1:0], bank[3:0]}, bank 15 = none
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {28'h0000100, 1'b1, 1'b1, 1'b1, 2'd0, 4'd0},  // R4 boot bank, R6 over bank2
        {28'h0800100, 1'b0, 1'b1, 1'b0, 2'd0, 4'd1},  // R6 bank1 over bank2, R10 upper only
        {28'h0800200, 1'b1, 1'b1, 1'b1, 2'd2, 4'd1},  // R9 two wait clocks
        {28'h2000000, 1'b1, 1'b0, 1'b0, 2'd0, 4'd2},  // R3 misaligned base masked
        {28'h2000000, 1'b0, 1'b0, 1'b1, 2'd1, 4'd2},  // R10 lower only, R9
        {28'h0FFC0010, 1'b0, 1'b1, 1'b1, 2'd0, 4'd7}, // R7 write timing set
        {28'hFFFFFFE, 1'b1, 1'b1, 1'b1, 2'd3, 4'd7},  // R7 read set, R9
        {28'hC000000, 1'b1, 1'b1, 1'b1, 2'd0, 4'd15}, // R5 no match
        {28'h6000000, 1'b1, 1'b1, 1'b1, 2'd0, 4'd15}, // R5 disabled bank3
        {28'h083FFFE, 1'b1, 1'b1, 1'b1, 2'd0, 4'd1},  // R3 top of 256 KB
        {28'h0840000, 1'b1, 1'b1, 1'b1, 2'd0, 4'd2},  // R3 one past bank1
        {28'hBFFFF00, 1'b1, 1'b1, 1'b1, 2'd0, 4'd4}   // R3 code 15 acts as 64 MB
    };

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic en, input logic [3:0] sz,
                                       input logic [9:0] base, input logic [7:0] wt,
                                       input logic [7:0] rt);
        return {en, sz, base, 1'b0, wt, rt};
    endfunction

    task automatic prog(input int b, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'(b); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        mw[b] = w[15:8];
        mr[b] = w[7:0];
    endtask

    task automatic launch(input logic [27:0] a, input logic rd, input logic hi, input logic lo);
        @(negedge clk);
        cyc_addr = a; cyc_rd = rd; cyc_be_hi = hi; cyc_be_lo = lo; cyc_valid = 1'b1;
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    // hook 1: pulse a bank2 request mid-cycle; hook 2: rewrite bank0 mid-cycle
    task automatic observe(input string pfx, input int bank, input logic rd,
                           input logic hi, input logic lo, input int w, input int hook);
        int s, a, h, cs_n, rd_n, hi_n, lo_n, ack_n, ack_at, bad_cs, stb;
        logic [7:0] t;
        cs_n = 0; rd_n = 0; hi_n = 0; lo_n = 0; ack_n = 0; ack_at = -1; bad_cs = 0;
        t = (bank < 8) ? (rd ? mr[bank] : mw[bank]) : 8'h00;
        s = int'(t[1:0]); a = int'(t[3:2]); h = int'(t[5:4]);
        for (int n = 0; n < 32; n++) begin
            if (n > 0) @(negedge clk);
            ext_wait = (bank < 8) && (w > 0) && (n - s >= a) && (n - s < a + w);
            if (hook == 1 && n == 2) begin
                cyc_addr = 28'h2000000; cyc_valid = 1'b1;
            end
            if (hook == 1 && n == 3) cyc_valid = 1'b0;
            if (hook == 2 && n == 1) begin
                cfg_we = 1'b1; cfg_bank = 3'd0;
                cfg_wdata = mk(1'b1, 4'd5, 10'h000, 8'h00, 8'h00);
            end
            if (hook == 2 && n == 2) cfg_we = 1'b0;
            #1;
            if (cs != 8'h00) cs_n++;
            if (cs != 8'h00 && (bank > 7 || cs != 8'(1 << bank))) bad_cs++;
            if (rd_stb) rd_n++;
            if (wr_hi_stb) hi_n++;
            if (wr_lo_stb) lo_n++;
            if (ack) begin ack_n++; ack_at = n; end
        end
        ext_wait = 1'b0;
        if (bank < 8) begin
            stb = a + 1 + w;
            check({pfx, " R7 chip-select clocks"}, cs_n, s + stb + h);
            check({pfx, " R1 R6 selected bank"}, bad_cs, 0);
            check({pfx, " R10 read strobe clocks"}, rd_n, rd ? stb : 0);
            check({pfx, " R10 upper write clocks"}, hi_n, (!rd && hi) ? stb : 0);
            check({pfx, " R10 lower write clocks"}, lo_n, (!rd && lo) ? stb : 0);
            check({pfx, " R8 ack count"}, ack_n, 1);
            check({pfx, " R8 R9 ack position"}, ack_at, s + a + w);
        end else begin
            check({pfx, " R5 no chip select"}, cs_n, 0);
            check({pfx, " R5 no strobe"}, rd_n + hi_n + lo_n, 0);
            check({pfx, " R5 no ack"}, ack_n, 0);
        end
    endtask

    task automatic gap_test(input string tag, input logic [27:0] a, input logic rd, input int exp);
        int seen, off, gap;
        seen = 0; off = 0; gap = -1;
        @(negedge clk);
        cyc_addr = a; cyc_rd = rd; cyc_be_hi = 1'b1; cyc_be_lo = 1'b1; cyc_valid = 1'b1;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            #1;
            if (cs != 8'h00) begin
                if (seen != 0 && off > 0 && gap < 0) gap = off;
                seen = 1;
            end else if (seen != 0 && gap < 0) begin
                off++;
            end
        end
        cyc_valid = 1'b0;
        repeat (30) @(negedge clk);
        check(tag, gap, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mr[i] = 8'h00; mw[i] = 8'h00; end
        mr[0] = 8'hFF; mw[0] = 8'hFF;
        repeat (3) @(negedge clk);
        #1;
        check("R4 reset chip selects", int'(cs), 0);
        check("R4 reset strobes and ack", int'({rd_stb, wr_hi_stb, wr_lo_stb, ack}), 0);
        rst_n = 1'b1;

        prog(1, mk(1'b1, 4'd0, 10'h020, 8'h84, 8'h11));
        prog(2, mk(1'b1, 4'd8, 10'h040, 8'h00, 8'h00));
        prog(3, mk(1'b0, 4'd2, 10'h180, 8'h00, 8'h00));
        prog(4, mk(1'b1, 4'd15, 10'h200, 8'h00, 8'h00));
        prog(7, mk(1'b1, 4'd0, 10'h3FF, 8'h29, 8'h46));

        for (int v = 0; v < NV; v++) begin
            logic [36:0] r;
            r = VEC[v];
            launch(r[36:9], r[8], r[7], r[6]);
            observe($sformatf("row%0d", v), int'(r[3:0]), r[8], r[7], r[6], int'(r[5:4]), 0);
        end

        gap_test("R7 recovery gap bank7 read", 28'hFFC0000, 1'b1, 2);
        gap_test("R7 recovery gap bank1 write", 28'h0800000, 1'b0, 3);
        gap_test("R7 recovery gap bank0 read", 28'h0000000, 1'b1, 4);

        // R11: a request during a busy cycle is dropped
        launch(28'h0000200, 1'b1, 1'b1, 1'b1);
        observe("R11 busy request", 0, 1'b1, 1'b1, 1'b1, 0, 1);

        // R12 and R2: mid-cycle rewrite applies to the next cycle only
        launch(28'h0000300, 1'b1, 1'b1, 1'b1);
        observe("R12 latched timing", 0, 1'b1, 1'b1, 1'b1, 0, 2);
        mr[0] = 8'h00; mw[0] = 8'h00;
        launch(28'h0000300, 1'b1, 1'b1, 1'b1);
        observe("R2 new timing", 0, 1'b1, 1'b1, 1'b1, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule